// File: doc/BRIEF.md
# PLL Control and Lock Sequencer

This block is the digital side of a phase-locked loop. It keeps one 32-bit control word with the feedback multiplier, input divider and output divider codes, an enable bit, a bypass bit and a stabilization time. From these it produces the effective multiply and divide ratios as plain numbers, so that the analog loop or a checker can consume them directly. A lock timer counts reference ticks after the loop is enabled and raises a stable flag once the programmed settling time has passed.

A small power sequencer sits around the enable bit. A suspend request first forces the hold (gate) lines of three peripheral clocks (timer, DMA, first UART) and then powers the loop down. A resume request powers the loop up, waits for the stable flag, and only then releases those hold lines. Software uses the single write/read port for everything else.

Top module: `pll_ctl_seq`

## Requirements
- R1: After reset the control word reads 0x0000_0200 (bypass set, loop disabled, all codes zero), `pll_stable` is 0 and `gate_hold` is 0.
- R2: With bypass clear, `mult_eff` equals the 9-bit multiplier code in bits 31:23 plus 2.
- R3: With bypass clear, `prediv_eff` equals the 5-bit input divider code in bits 22:18 plus 2.
- R4: With bypass clear, the 2-bit output divider code in bits 17:16 gives `postdiv_eff` of 1, 2, 2, 4 for codes 0, 1, 2, 3.
- R5: With bypass (bit 9) set, `mult_eff`, `prediv_eff` and `postdiv_eff` are all 1 whatever the codes hold.
- R6: Bit 10 of the control word reads the stable flag; a write to bit 10 has no effect on it.
- R7: The stable flag is 0 in the same cycle the enable bit (bit 8) reads 0.
- R8: With stabilization code S in bits 3:0 and scale K, after enable rises the flag reads 1 one cycle after S*K reference ticks have been counted, and never earlier; with S=0 it reads 1 in the second enabled cycle.
- R9: A suspend request in the idle state sets all three `gate_hold` bits (bit 0 timer, bit 1 DMA, bit 2 UART) at the next edge and clears the enable bit one edge later.
- R10: A resume request in the idle state sets the enable bit at the next edge; `gate_hold` stays all ones until the stable flag has been seen and clears at the edge after that.
- R11: Suspend and resume requests arriving while a sequence is in progress are ignored.
- R12: Writes update every writable field at the next edge; the sequencer's enable change wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word including stable flag |
| ref_tick | input | 1 | One-cycle reference tick for the lock timer |
| suspend_req | input | 1 | Start the power-down sequence |
| resume_req | input | 1 | Start the power-up sequence |
| pll_en | output | 1 | Loop enable |
| pll_stable | output | 1 | Loop settled flag |
| gate_hold | output | 3 | Peripheral clock hold lines: timer, DMA, UART |
| mult_eff | output | 10 | Effective feedback multiplier |
| prediv_eff | output | 6 | Effective input divider |
| postdiv_eff | output | 3 | Effective output divider |

## Verification
Every cycle the assertions check that the flag is never up in the first enabled cycle, that it drops with the enable, that the loop is only powered down with all hold lines set, and that the hold lines are only released after the flag was seen. The exact settling count for every stabilization code under a sparse tick pattern, the full decode of every multiplier, divider and output code, the masking by bypass, and the rejection of requests mid-sequence are shown only by the bench scenarios.

// File: rtl/pll_ctl_pkg.sv
// Package: control word layout and shared types for the PLL controller.
// Assumes a 32-bit control word; field positions are fixed because software
// and the sequencer decode them.
package pll_ctl_pkg;
    localparam int WORD_W  = 32;
    localparam int MUL_LSB = 23;
    localparam int MUL_W   = 9;
    localparam int PRE_LSB = 18;
    localparam int PRE_W   = 5;
    localparam int PST_LSB = 16;
    localparam int PST_W   = 2;
    localparam int STB_BIT = 10;
    localparam int BYP_BIT = 9;
    localparam int ENA_BIT = 8;
    localparam int SET_LSB = 0;
    localparam int SET_W   = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DROP = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

    // Output divider code to division ratio (non-binary map).
    function automatic logic [2:0] postdiv_of(input logic [PST_W-1:0] code);
        case (code)
            2'd0:    postdiv_of = 3'd1;
            2'd1,
            2'd2:    postdiv_of = 3'd2;
            default: postdiv_of = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/pll_ctl_regs.sv
// Module: control word storage and ratio decode.
// Holds the writable fields, merges the sequencer's enable set/clear
// (which beats a bus write) and presents effective ratios.
// Assumes the stable flag comes from the lock timer.
module pll_ctl_regs
    import pll_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                set_en_i,
    input  logic                clr_en_i,
    input  logic                stable_i,
    output logic [WORD_W-1:0]   rd_data,
    output logic                en_o,
    output logic [SET_W-1:0]    settle_o,
    output logic [MUL_W:0]      mult_o,
    output logic [PRE_W:0]      prediv_o,
    output logic [2:0]          postdiv_o
);
    logic [MUL_W-1:0] mul_q;
    logic [PRE_W-1:0] pre_q;
    logic [PST_W-1:0] pst_q;
    logic [SET_W-1:0] set_q;
    logic             byp_q;
    logic             en_q;

    // Field registers; reset leaves the loop off and bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mul_q <= '0;
            pre_q <= '0;
            pst_q <= '0;
            set_q <= '0;
            byp_q <= 1'b1;
        end else if (wr_en) begin
            mul_q <= wr_data[MUL_LSB +: MUL_W];
            pre_q <= wr_data[PRE_LSB +: PRE_W];
            pst_q <= wr_data[PST_LSB +: PST_W];
            set_q <= wr_data[SET_LSB +: SET_W];
            byp_q <= wr_data[BYP_BIT];
        end
    end

    // Enable bit: sequencer actions take priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (set_en_i)
            en_q <= 1'b1;
        else if (clr_en_i)
            en_q <= 1'b0;
        else if (wr_en)
            en_q <= wr_data[ENA_BIT];
    end

    // Read-back word assembly.
    always_comb begin
        rd_data = '0;
        rd_data[MUL_LSB +: MUL_W] = mul_q;
        rd_data[PRE_LSB +: PRE_W] = pre_q;
        rd_data[PST_LSB +: PST_W] = pst_q;
        rd_data[SET_LSB +: SET_W] = set_q;
        rd_data[STB_BIT]          = stable_i;
        rd_data[BYP_BIT]          = byp_q;
        rd_data[ENA_BIT]          = en_q;
    end

    // Effective ratios; bypass passes the reference straight through.
    always_comb begin
        if (byp_q) begin
            mult_o    = (MUL_W+1)'(1);
            prediv_o  = (PRE_W+1)'(1);
            postdiv_o = 3'd1;
        end else begin
            mult_o    = {1'b0, mul_q} + (MUL_W+1)'(2);
            prediv_o  = {1'b0, pre_q} + (PRE_W+1)'(2);
            postdiv_o = postdiv_of(pst_q);
        end
    end

    assign en_o     = en_q;
    assign settle_o = set_q;

    p_ratio_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(postdiv_o) == 1);
endmodule

// File: rtl/pll_lock_timer.sv
// Module: stabilization timer.
// Counts reference ticks while enabled and not yet stable; the flag is
// set one edge after the count reaches settle*SCALE and is masked at once
// by a low enable. Assumes ref_tick is a single-cycle pulse.
module pll_lock_timer #(
    parameter int SET_W = 4,
    parameter int SCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             en_i,
    input  logic [SET_W-1:0] settle_i,
    output logic             stable_o
);
    localparam int CNT_W = SET_W + $clog2(SCALE) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;
    logic             stable_q;

    assign target = CNT_W'(settle_i) * CNT_W'(SCALE);

    // Tick counter and settled flag; cleared whenever the loop is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q    <= '0;
            stable_q <= 1'b0;
        end else if (!stable_q) begin
            if (cnt_q >= target)
                stable_q <= 1'b1;
            else if (ref_tick_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable_o = stable_q & en_i;

    p_no_early_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |-> !stable_o);
endmodule

// File: rtl/pll_pm_seq.sv
// Module: suspend/resume sequencer.
// Suspend: hold the peripheral clocks, then drop the enable.
// Resume: raise the enable, wait for stable, then release the holds.
// Assumes requests are sampled only in the idle state; suspend wins a tie.
module pll_pm_seq
    import pll_ctl_pkg::*;
#(
    parameter int GATE_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              suspend_req_i,
    input  logic              resume_req_i,
    input  logic              stable_i,
    output logic              set_en_o,
    output logic              clr_en_o,
    output logic [GATE_N-1:0] gate_o
);
    seq_state_e        st_q;
    logic [GATE_N-1:0] gate_q;

    assign set_en_o = (st_q == SEQ_IDLE) && resume_req_i && !suspend_req_i;
    assign clr_en_o = (st_q == SEQ_DROP);
    assign gate_o   = gate_q;

    // State and hold-line register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            gate_q <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (suspend_req_i) begin
                        gate_q <= '1;
                        st_q   <= SEQ_DROP;
                    end else if (resume_req_i) begin
                        st_q   <= SEQ_WAIT;
                    end
                end
                SEQ_DROP: st_q <= SEQ_IDLE;
                SEQ_WAIT: begin
                    if (stable_i) begin
                        gate_q <= '0;
                        st_q   <= SEQ_IDLE;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    p_gates_before_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_o |-> (&gate_q));

    p_release_after_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_q[0]) |-> $past(stable_i));
endmodule

// File: rtl/pll_ctl_seq.sv
// Module: top of the PLL controller.
// Ties the control word, lock timer and power sequencer together.
// Assumes one clock domain; ref_tick is already synchronous to clk.
module pll_ctl_seq
    import pll_ctl_pkg::*;
#(
    parameter int STAB_SCALE = 4,
    parameter int GATE_N     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              ref_tick,
    input  logic              suspend_req,
    input  logic              resume_req,
    output logic              pll_en,
    output logic              pll_stable,
    output logic [GATE_N-1:0] gate_hold,
    output logic [9:0]        mult_eff,
    output logic [5:0]        prediv_eff,
    output logic [2:0]        postdiv_eff
);
    logic             set_en;
    logic             clr_en;
    logic [SET_W-1:0] settle;

    pll_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .set_en_i  (set_en),
        .clr_en_i  (clr_en),
        .stable_i  (pll_stable),
        .rd_data   (rd_data),
        .en_o      (pll_en),
        .settle_o  (settle),
        .mult_o    (mult_eff),
        .prediv_o  (prediv_eff),
        .postdiv_o (postdiv_eff)
    );

    pll_lock_timer #(.SET_W(SET_W), .SCALE(STAB_SCALE)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick),
        .en_i       (pll_en),
        .settle_i   (settle),
        .stable_o   (pll_stable)
    );

    pll_pm_seq #(.GATE_N(GATE_N)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .suspend_req_i (suspend_req),
        .resume_req_i  (resume_req),
        .stable_i      (pll_stable),
        .set_en_o      (set_en),
        .clr_en_o      (clr_en),
        .gate_o        (gate_hold)
    );

    p_drop_with_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> !pll_stable);
endmodule

// File: tb/pll_ctl_seq_tb.sv
module pll_ctl_seq_tb;
    localparam int K = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ref_tick = 1'b0;
    logic        suspend_req = 1'b0;
    logic        resume_req = 1'b0;
    logic        pll_en;
    logic        pll_stable;
    logic [2:0]  gate_hold;
    logic [9:0]  mult_eff;
    logic [5:0]  prediv_eff;
    logic [2:0]  postdiv_eff;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_ctl_seq #(.STAB_SCALE(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ref_tick(ref_tick), .suspend_req(suspend_req),
        .resume_req(resume_req), .pll_en(pll_en), .pll_stable(pll_stable),
        .gate_hold(gate_hold), .mult_eff(mult_eff), .prediv_eff(prediv_eff),
        .postdiv_eff(postdiv_eff)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] word(input int m, input int n, input int od,
                                         input bit byp, input bit en, input int s);
        return (32'(m) << 23) | (32'(n) << 18) | (32'(od) << 16) |
               (32'(byp) << 9) | (32'(en) << 8) | 32'(s);
    endfunction

    task automatic write(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int tb;
        int tgt;
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 word", rd_data, 32'h0000_0200);
        check("R1 stable", 32'(pll_stable), 0);
        check("R1 gates", 32'(gate_hold), 0);
        check("R5 reset bypass mult", 32'(mult_eff), 1);

        // R2 every multiplier code
        for (int m = 0; m < 512; m++) begin
            write(word(m, 0, 0, 0, 0, 0));
            check("R2 mult", 32'(mult_eff), 32'(m + 2));
            check("R12 readback", rd_data, word(m, 0, 0, 0, 0, 0));
        end
        // R3 every input divider code
        for (int n = 0; n < 32; n++) begin
            write(word(5, n, 0, 0, 0, 0));
            check("R3 prediv", 32'(prediv_eff), 32'(n + 2));
        end
        // R4 output divider map
        for (int od = 0; od < 4; od++) begin
            write(word(5, 3, od, 0, 0, 0));
            check("R4 postdiv", 32'(postdiv_eff), (od == 0) ? 1 : (od == 3) ? 4 : 2);
        end
        // R5 bypass masks every field
        for (int i = 0; i < 8; i++) begin
            write(word(i * 61 + 3, i * 4 + 1, i % 4, 1, 0, 0));
            check("R5 mult", 32'(mult_eff), 1);
            check("R5 prediv", 32'(prediv_eff), 1);
            check("R5 postdiv", 32'(postdiv_eff), 1);
        end

        // R6 write to stable bit ignored while disabled
        write(word(1, 1, 1, 0, 0, 0) | 32'h400);
        check("R6 ignored off", 32'(rd_data[10]), 0);
        check("R6 stable off", 32'(pll_stable), 0);

        // R8 settle count for every code, ticks on odd cycles
        for (int s = 0; s < 16; s++) begin
            write(word(1, 1, 1, 0, 0, s));
            ref_tick = 1'b0;
            write(word(1, 1, 1, 0, 1, s));
            tgt = s * K;
            tb = 0;
            for (int j = 1; j <= 2 * tgt + 4; j++) begin
                ref_tick = j[0];
                step();
                check("R8 settle", 32'(pll_stable), 32'(tb >= tgt));
                tb += int'(ref_tick);
            end
            ref_tick = 1'b0;
        end
        // R6 clearing bit 10 by write does not drop a set flag
        write(word(1, 1, 1, 0, 1, 15));
        check("R6 kept", 32'(rd_data[10]), 1);
        // R7 flag drops with the enable
        write(word(1, 1, 1, 0, 0, 15) | 32'h400);
        check("R7 drop", 32'(pll_stable), 0);
        check("R7 word", 32'(rd_data[10]), 0);

        // R9 suspend sequence from a running loop
        ref_tick = 1'b1;
        write(word(1, 1, 1, 0, 1, 1));
        repeat (8) step();
        check("R9 pre stable", 32'(pll_stable), 1);
        suspend_req = 1'b1;
        step();
        suspend_req = 1'b0;
        check("R9 gates set", 32'(gate_hold), 7);
        check("R9 still on", 32'(pll_en), 1);
        step();
        check("R9 off", 32'(pll_en), 0);
        check("R9 gates kept", 32'(gate_hold), 7);

        // R10 resume sequence
        resume_req = 1'b1;
        step();
        resume_req = 1'b0;
        check("R10 on", 32'(pll_en), 1);
        for (int j = 0; j < 20 && !pll_stable; j++) begin
            check("R10 held", 32'(gate_hold), 7);
            step();
        end
        check("R10 locked", 32'(pll_stable), 1);
        check("R10 held at lock", 32'(gate_hold), 7);
        step();
        check("R10 released", 32'(gate_hold), 0);

        // R11 request mid-sequence ignored
        write(word(1, 1, 1, 0, 1, 15));
        suspend_req = 1'b1;
        step();
        suspend_req = 1'b0;
        step();
        check("R11 suspended", 32'(pll_en), 0);
        resume_req = 1'b1;
        step();
        resume_req = 1'b0;
        check("R11 resumed", 32'(pll_en), 1);
        suspend_req = 1'b1;
        step();
        suspend_req = 1'b0;
        step();
        check("R11 enable kept", 32'(pll_en), 1);
        check("R11 gates kept", 32'(gate_hold), 7);
        repeat (70) step();
        check("R11 finished", 32'(gate_hold), 0);
        check("R11 locked", 32'(pll_stable), 1);

        // R12 sequencer beats a same-cycle write
        suspend_req = 1'b1;
        step();
        suspend_req = 1'b0;
        wr_en = 1'b1;
        wr_data = word(1, 1, 1, 0, 1, 15);
        step();
        wr_en = 1'b0;
        check("R12 priority", 32'(pll_en), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule